// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Generator

This block produces the address-latch strobe and the write strobe for a single access on an external asynchronous memory bus. Both strobes are active low. A one-cycle start pulse opens an access and gives its direction. The same pulse presents a packed word of edge times. Every edge time is a count of functional-clock periods measured from the start edge. The address-latch strobe has one release time for reads and another for writes. Each strobe can be moved half a period later by re-registering it on the falling clock edge.

The block takes its timing word from a surrounding controller and returns a done pulse once the longest programmed window has ended. The controller can then issue the next access. The timing word and the direction are captured on the start pulse, so the controller may load new values while an access is still running. A fresh start pulse during an access drops that access and begins a new one.

Period numbering: the period that follows the clock edge which samples `start_i` high is period 0, the next one is period 1, and so on.

Top module: `strobe_timer`

## Requirements
- R1: While `rst_ni` is low, `adv_no` and `we_no` are high and `done_o` is low.
- R2: Without its half-period delay, `adv_no` is low exactly in periods k where on ≤ k < off. Here on is the address-strobe on time in `cfg_i[3:0]`. For a read, off is taken from `cfg_i[8:4]`. For a write, off is taken from `cfg_i[13:9]`.
- R3: Without its half-period delay, `we_no` is low exactly in periods k where we_on ≤ k < we_off. For writes, we_on is `cfg_i[18:15]` and we_off is `cfg_i[23:19]`. During a read, `we_no` stays high for the whole access.
- R4: When a strobe's off time is less than or equal to its on time, that strobe stays high for the entire access.
- R5: When `cfg_i[14]` is set, both edges of `adv_no` move half a period later. When `cfg_i[24]` is set, both edges of `we_no` move half a period later. The two bits act independently.
- R6: `done_o` is high for exactly one period, period k = last. For a read, last is the read release time of the address strobe. For a write, last is the larger of the write release time of the address strobe and we_off. After that period the block is idle with both strobes high.
- R7: `cfg_i` and `write_i` are captured on the start pulse. Changes to them while an access runs have no effect on that access.
- R8: A start pulse during an access restarts the count at period 0, using the newly presented fields and direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens an access |
| write_i | input | 1 | Direction of the access, 1 = write |
| cfg_i | input | 25 | Packed edge times and half-period delay bits |
| adv_no | output | 1 | Address-latch strobe, active low |
| we_no | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-period pulse at the end of the access |

## Verification
The assertions assume that `start_i` is synchronous to the rising edge and that `cfg_i` and `write_i` are valid whenever `start_i` is high. They place no other condition on these inputs. The bench changes every input only mid-period, well away from both clock edges, so that the falling-edge stage always captures a settled rising-edge value. The bench also deliberately changes `cfg_i` during accesses and issues overlapping start pulses, so that the capture and restart rules are exercised within these assumptions.

// File: rtl/strobe_timer_pkg.sv
package strobe_timer_pkg;
  parameter int unsigned ON_W  = 4;
  parameter int unsigned OFF_W = 5;

  typedef struct packed {
    logic             we_half;
    logic [OFF_W-1:0] we_off;
    logic [ON_W-1:0]  we_on;
    logic             adv_half;
    logic [OFF_W-1:0] adv_off_wr;
    logic [OFF_W-1:0] adv_off_rd;
    logic [ON_W-1:0]  adv_on;
  } timing_cfg_t;

  localparam int unsigned CFG_W = $bits(timing_cfg_t);

  localparam timing_cfg_t CFG_RST = '{
    we_half:    1'b0,
    we_off:     OFF_W'(16),
    we_on:      ON_W'(0),
    adv_half:   1'b0,
    adv_off_wr: OFF_W'(2),
    adv_off_rd: OFF_W'(2),
    adv_on:     ON_W'(1)
  };
endpackage

// File: rtl/strobe_cycle_counter.sv
module strobe_cycle_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             go_nxt_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic             active_q_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             at_last;

  assign at_last = active_q && (cnt_q == last_i);

  always_comb begin
    go_nxt_o  = start_i || (active_q && !at_last);
    cnt_nxt_o = start_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (at_last) active_q <= 1'b0;
      else         cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_q_o    = cnt_q;
  assign active_q_o = active_q;
  assign done_o     = at_last;
endmodule

// File: rtl/strobe_edge_gen.sv
module strobe_edge_gen #(
  parameter int unsigned ON_W  = 4,
  parameter int unsigned OFF_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             enable_i,
  input  logic [OFF_W-1:0] cnt_i,
  input  logic [ON_W-1:0]  on_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             half_i,
  output logic             strobe_no
);
  logic win;
  logic pos_nq;
  logic neg_nq;

  assign win = go_i && enable_i && (OFF_W'(on_i) <= cnt_i) && (cnt_i < off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_nq <= 1'b1;
    else         pos_nq <= ~win;
  end

  // half-period retime: falling edge copy of the rising edge flop
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_nq <= 1'b1;
    else         neg_nq <= pos_nq;
  end

  assign strobe_no = half_i ? neg_nq : pos_nq;
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
  import strobe_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             adv_no,
  output logic             we_no,
  output logic             done_o
);
  timing_cfg_t      cfg_in;
  timing_cfg_t      cfg_q;
  timing_cfg_t      cfg_eff;
  logic             write_q;
  logic             write_eff;
  logic [OFF_W-1:0] adv_off_eff;
  logic [OFF_W-1:0] last_q;
  logic [OFF_W-1:0] cnt_nxt;
  logic [OFF_W-1:0] cnt_q;
  logic             go_nxt;
  logic             active_q;

  assign cfg_in = timing_cfg_t'(cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_RST;
      write_q <= 1'b0;
    end else if (start_i) begin
      cfg_q   <= cfg_in;
      write_q <= write_i;
    end
  end

  always_comb begin
    cfg_eff     = start_i ? cfg_in : cfg_q;
    write_eff   = start_i ? write_i : write_q;
    adv_off_eff = write_eff ? cfg_eff.adv_off_wr : cfg_eff.adv_off_rd;
    if (!write_q)                            last_q = cfg_q.adv_off_rd;
    else if (cfg_q.adv_off_wr > cfg_q.we_off) last_q = cfg_q.adv_off_wr;
    else                                     last_q = cfg_q.we_off;
  end

  strobe_cycle_counter #(.CNT_W(OFF_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_i     (last_q),
    .cnt_nxt_o  (cnt_nxt),
    .go_nxt_o   (go_nxt),
    .cnt_q_o    (cnt_q),
    .active_q_o (active_q),
    .done_o     (done_o)
  );

  strobe_edge_gen #(.ON_W(ON_W), .OFF_W(OFF_W)) u_adv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go_nxt),
    .enable_i  (1'b1),
    .cnt_i     (cnt_nxt),
    .on_i      (cfg_eff.adv_on),
    .off_i     (adv_off_eff),
    .half_i    (cfg_q.adv_half),
    .strobe_no (adv_no)
  );

  strobe_edge_gen #(.ON_W(ON_W), .OFF_W(OFF_W)) u_we (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go_nxt),
    .enable_i  (write_eff),
    .cnt_i     (cnt_nxt),
    .on_i      (cfg_eff.we_on),
    .off_i     (cfg_eff.we_off),
    .half_i    (cfg_q.we_half),
    .strobe_no (we_no)
  );
endmodule

// File: rtl/strobe_timer_chk.sv
module strobe_timer_chk
  import strobe_timer_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             write_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             adv_no,
  input logic             we_no,
  input logic             done_o,
  input logic [CFG_W-1:0] cfg_q,
  input logic             write_q,
  input logic [OFF_W-1:0] cnt_q,
  input logic             active_q
);
  timing_cfg_t      c_in;
  logic [OFF_W-1:0] adv_off_sel;

  assign c_in        = timing_cfg_t'(cfg_i);
  assign adv_off_sel = write_i ? c_in.adv_off_wr : c_in.adv_off_rd;

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  p_idle_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> adv_no && we_no);

  p_read_we_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !write_i |=> we_no);

  p_empty_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (OFF_W'(c_in.adv_on) >= adv_off_sel) |=> adv_no);

  p_hold_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(cfg_q) && $stable(write_q));

  p_restart_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_q && (cnt_q == '0));
endmodule

bind strobe_timer strobe_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .write_i  (write_i),
  .cfg_i    (cfg_i),
  .adv_no   (adv_no),
  .we_no    (we_no),
  .done_o   (done_o),
  .cfg_q    (cfg_q),
  .write_q  (write_q),
  .cnt_q    (cnt_q),
  .active_q (active_q)
);

// File: tb/strobe_timer_test.sv
module strobe_timer_test;
  import strobe_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_s = 1'b0;
  logic        wr_s = 1'b0;
  timing_cfg_t cfg_s = CFG_RST;
  logic        adv_n, we_n, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  strobe_timer uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start_s),
    .write_i (wr_s),
    .cfg_i   (cfg_s),
    .adv_no  (adv_n),
    .we_no   (we_n),
    .done_o  (done)
  );

  // behavioural reference
  bit          m_act, m_wr, m_done;
  int          m_k;
  timing_cfg_t m_c = CFG_RST;
  bit          adv_cur, adv_prv, we_cur, we_prv;

  function automatic int last_of(timing_cfg_t c, bit w);
    int a;
    if (!w) return int'(c.adv_off_rd);
    a = int'(c.adv_off_wr);
    return (a > int'(c.we_off)) ? a : int'(c.we_off);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_k = 0; m_wr = 0; m_c = CFG_RST;
      adv_cur = 0; adv_prv = 0; we_cur = 0; we_prv = 0; m_done = 0;
    end else begin
      adv_prv = adv_cur;
      we_prv  = we_cur;
      if (start_s) begin
        m_act = 1; m_k = 0; m_c = cfg_s; m_wr = wr_s;
      end else if (m_act && m_k == last_of(m_c, m_wr)) m_act = 0;
      else if (m_act) m_k++;
      adv_cur = m_act && m_k >= int'(m_c.adv_on) &&
                m_k < int'(m_wr ? m_c.adv_off_wr : m_c.adv_off_rd);
      we_cur  = m_act && m_wr && m_k >= int'(m_c.we_on) && m_k < int'(m_c.we_off);
      m_done  = m_act && m_k == last_of(m_c, m_wr);
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    check(m_c.adv_half ? "R5 adv early" : {tag, " adv early"}, adv_n,
          m_c.adv_half ? !adv_prv : !adv_cur);
    check(m_c.we_half ? "R5 we early" : {tag, " R3 we early"}, we_n,
          m_c.we_half ? !we_prv : !we_cur);
    check({tag, " R6 done"}, done, m_done);
    #2.5;
    check({tag, " adv late"}, adv_n, !adv_cur);
    check({tag, " R3 we late"}, we_n, !we_cur);
  end

  function automatic timing_cfg_t mk(int aon, int ard, int awr, bit ah,
                                     int won, int woff, bit wh);
    timing_cfg_t c;
    c.adv_on = ON_W'(aon);   c.adv_off_rd = OFF_W'(ard);
    c.adv_off_wr = OFF_W'(awr); c.adv_half = ah;
    c.we_on = ON_W'(won);    c.we_off = OFF_W'(woff); c.we_half = wh;
    return c;
  endfunction

  task automatic go(timing_cfg_t c, bit w);
    @(posedge clk); #2;
    cfg_s = c; wr_s = w; start_s = 1'b1;
    @(posedge clk); #2;
    start_s = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    idle(4);
    #2 rst_n = 1'b1;
    tag = "R2"; go(mk(1, 4, 9, 0, 0, 0, 0), 0); idle(8);
    go(mk(0, 3, 5, 0, 2, 6, 0), 1); idle(10);
    tag = "R3"; go(mk(2, 5, 3, 0, 1, 7, 0), 0); idle(10);
    go(mk(3, 2, 6, 0, 3, 10, 0), 1); idle(14);
    tag = "R4"; go(mk(5, 3, 3, 0, 7, 7, 0), 1); idle(10);
    go(mk(9, 9, 4, 0, 0, 0, 0), 0); idle(12);
    tag = "R5"; go(mk(1, 4, 6, 1, 2, 8, 0), 1); idle(12);
    go(mk(1, 4, 6, 0, 2, 8, 1), 1); idle(12);
    go(mk(0, 4, 6, 1, 0, 5, 1), 1); idle(12);
    tag = "R6"; go(mk(0, 0, 0, 0, 0, 0, 0), 0); idle(4);
    go(mk(15, 31, 31, 0, 15, 31, 0), 1); idle(36);
    tag = "R7"; go(mk(1, 6, 8, 0, 2, 7, 0), 1);
    idle(2); #2 cfg_s = mk(0, 2, 2, 1, 0, 20, 1); wr_s = 1'b0;
    idle(14);
    tag = "R8"; go(mk(1, 8, 12, 0, 2, 10, 0), 1); idle(3);
    go(mk(0, 5, 3, 1, 0, 9, 1), 1); idle(3);
    go(mk(2, 6, 4, 0, 1, 3, 0), 0); idle(12);
    tag = "R2";
    for (int i = 0; i < 24; i++) begin
      go(mk((i * 3) % 16, (i * 7) % 32, (i * 5 + 3) % 32, i[1],
            (i * 11) % 16, (i * 13 + 1) % 32, i[2]), i[0]);
      idle((i % 3 == 0) ? 36 : (i % 5));
    end
    tag = "R1"; #1 rst_n = 1'b0; idle(3); #1 rst_n = 1'b1; idle(2);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule